// File: doc/BRIEF.md
# Immediate Decoder and Branch Target Unit

This block turns a 32-bit RISC-V instruction word into the immediate operand it carries and adds that operand to the instruction's program counter, giving the target a branch or jump would reach. The major opcode alone picks one of five immediate shapes: register-immediate, store, conditional branch, upper immediate and jump. Each result bit is then a small selection among a few fixed instruction bits or zero. The block never extracts a field and shifts it afterwards. Every sign-extended result takes its sign from instruction bit 31, so in a 64-bit build the upper half of the immediate is simply copies of that bit.

For system instructions the block also produces the 5-bit register-select field as a zero-extended unsigned immediate. All results pass through one register stage with a valid flag. A front end feeds one instruction per cycle and reads the immediate, target and unsigned immediate one clock later. Opcodes outside the supported set yield a zero immediate.

Top module: `imm_target_unit`

## Requirements
- R1: The immediate shape is chosen from instr[6:0] only: 0010011, 0000011 and 1100111 select the I shape, 0100011 the S shape, 1100011 the B shape, 0110111 and 0010111 the U shape, and 1101111 the J shape.
- R2: The I shape gives instr[31:20] sign-extended to XLEN bits.
- R3: The S shape gives {instr[31:25], instr[11:7]} sign-extended.
- R4: The B shape gives {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended, so bit 0 is always zero and instr[7] supplies immediate bit 11.
- R5: The U shape gives instr[31:12] in immediate bits 31:12 with bits 11:0 zero.
- R6: The J shape gives {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended, so bit 0 is always zero.
- R7: Any other opcode, including register-register (0110011) and system (1110011), gives an all-zero immediate.
- R8: For every supported shape the immediate's bits from 31 up to XLEN-1 equal instr[31].
- R9: The target output equals the captured pc plus the immediate, modulo 2^XLEN.
- R10: For opcode 1110011 the unsigned immediate output is instr[19:15] zero-extended; for every other opcode it is zero.
- R11: Results appear one clock after in_valid is sampled high, with out_valid high in that cycle; a cycle with in_valid low drops out_valid and leaves imm_o, target_o and uimm_o unchanged.
- R12: While rst_n is low, out_valid, imm_o, target_o and uimm_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and pc are valid this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the instruction |
| out_valid | output | 1 | Registered results are valid |
| imm_o | output | XLEN | Decoded immediate |
| target_o | output | XLEN | pc plus immediate |
| uimm_o | output | XLEN | Zero-extended 5-bit system immediate |

## Verification
The hardest case to reach is one where a shape takes a bit from a place other shapes use differently: a branch whose only set immediate bit comes from instr[7], or a jump whose bit 11 comes from instr[20], while instr[31] is zero, so that a mux picking the wrong source shows up as a plain wrong value rather than hiding behind sign fill. The vector table builds such words by hand, next to words of all ones in the upper bits and offsets of -2, -8 and -2048 that carry a wrap-around into the target adder. A hold cycle with a changed instruction and in_valid low then confirms that nothing is captured.

// File: rtl/imm_pkg.sv
package imm_pkg;

   typedef enum logic [2:0] {
      SHP_NONE = 3'd0,
      SHP_I    = 3'd1,
      SHP_S    = 3'd2,
      SHP_B    = 3'd3,
      SHP_U    = 3'd4,
      SHP_J    = 3'd5
   } imm_shape_e;

   localparam logic [6:0] OPC_ALU_IMM = 7'b0010011;
   localparam logic [6:0] OPC_LOAD    = 7'b0000011;
   localparam logic [6:0] OPC_JALR    = 7'b1100111;
   localparam logic [6:0] OPC_STORE   = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
   localparam logic [6:0] OPC_LUI     = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC   = 7'b0010111;
   localparam logic [6:0] OPC_JAL     = 7'b1101111;
   localparam logic [6:0] OPC_SYSTEM  = 7'b1110011;

   localparam int INSN_W  = 32;
   localparam int UIMM_W  = 5;

endpackage

// File: rtl/imm_shape_sel.sv
module imm_shape_sel
   import imm_pkg::*;
(
   input  logic [6:0]  opcode,
   output imm_shape_e  shape,
   output logic        is_system
);

   always_comb begin
      unique case (opcode)
         OPC_ALU_IMM, OPC_LOAD, OPC_JALR: shape = SHP_I;
         OPC_STORE:                       shape = SHP_S;
         OPC_BRANCH:                      shape = SHP_B;
         OPC_LUI, OPC_AUIPC:              shape = SHP_U;
         OPC_JAL:                         shape = SHP_J;
         default:                         shape = SHP_NONE;
      endcase
   end

   assign is_system = (opcode == OPC_SYSTEM);

endmodule

// File: rtl/imm_bit_mux.sv
module imm_bit_mux
   import imm_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [INSN_W-1:7] ins,
   input  imm_shape_e        shape,
   output logic [XLEN-1:0]   imm
);

   logic sel_i, sel_s, sel_b, sel_u, sel_j, sel_sx, sel_any;

   assign sel_i   = (shape == SHP_I);
   assign sel_s   = (shape == SHP_S);
   assign sel_b   = (shape == SHP_B);
   assign sel_u   = (shape == SHP_U);
   assign sel_j   = (shape == SHP_J);
   assign sel_sx  = sel_i | sel_s | sel_b | sel_j;
   assign sel_any = sel_sx | sel_u;

   // Each result bit picks from at most three fixed instruction bits.
   for (genvar k = 0; k < XLEN; k++) begin : g_bit
      if (k == 0) begin : g_b0
         assign imm[k] = (sel_i & ins[20]) | (sel_s & ins[7]);
      end else if (k < 5) begin : g_lo
         assign imm[k] = ((sel_i | sel_j) & ins[20+k])
                       | ((sel_s | sel_b) & ins[7+k]);
      end else if (k < 11) begin : g_mid
         assign imm[k] = sel_sx & ins[20+k];
      end else if (k == 11) begin : g_b11
         assign imm[k] = ((sel_i | sel_s) & ins[31])
                       | (sel_b & ins[7])
                       | (sel_j & ins[20]);
      end else if (k < 20) begin : g_up
         assign imm[k] = ((sel_i | sel_s | sel_b) & ins[31])
                       | ((sel_u | sel_j) & ins[k]);
      end else if (k < 31) begin : g_top
         assign imm[k] = (sel_u & ins[k]) | (sel_sx & ins[31]);
      end else begin : g_sign
         assign imm[k] = sel_any & ins[31];
      end
   end

endmodule

// File: rtl/imm_target_add.sv
module imm_target_add #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] offset,
   output logic [XLEN-1:0] sum
);

   assign sum = base + offset;

endmodule

// File: rtl/imm_target_unit.sv
module imm_target_unit
   import imm_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter bit CSR_UIMM_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] pc,
   output logic            out_valid,
   output logic [XLEN-1:0] imm_o,
   output logic [XLEN-1:0] target_o,
   output logic [XLEN-1:0] uimm_o
);

   localparam int UPAD_W = XLEN - UIMM_W;

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("imm_target_unit: XLEN must be 32 or 64");
   end

   imm_shape_e      shape;
   logic            is_system;
   logic [XLEN-1:0] imm_d;
   logic [XLEN-1:0] tgt_d;
   logic [XLEN-1:0] uimm_d;

   imm_shape_sel u_sel (
      .opcode    (instr[6:0]),
      .shape     (shape),
      .is_system (is_system)
   );

   imm_bit_mux #(.XLEN(XLEN)) u_mux (
      .ins   (instr[31:7]),
      .shape (shape),
      .imm   (imm_d)
   );

   imm_target_add #(.XLEN(XLEN)) u_add (
      .base   (pc),
      .offset (imm_d),
      .sum    (tgt_d)
   );

   if (CSR_UIMM_EN) begin : g_uimm
      assign uimm_d = is_system ? {{UPAD_W{1'b0}}, instr[19:15]} : '0;
   end else begin : g_no_uimm
      logic unused_sys;
      assign unused_sys = is_system;
      assign uimm_d     = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         imm_o     <= '0;
         target_o  <= '0;
         uimm_o    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            imm_o    <= imm_d;
            target_o <= tgt_d;
            uimm_o   <= uimm_d;
         end
      end
   end

endmodule

// File: rtl/imm_target_chk.sv
module imm_target_chk
   import imm_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [31:0]     instr,
   input logic [XLEN-1:0] pc,
   input logic            out_valid,
   input logic [XLEN-1:0] imm_o,
   input logic [XLEN-1:0] target_o,
   input logic [XLEN-1:0] uimm_o
);

   logic in_b_or_j, in_known, in_unknown;

   assign in_b_or_j  = (instr[6:0] == OPC_BRANCH) || (instr[6:0] == OPC_JAL);
   assign in_known   = (instr[6:0] == OPC_ALU_IMM) || (instr[6:0] == OPC_LOAD)
                    || (instr[6:0] == OPC_JALR)    || (instr[6:0] == OPC_STORE)
                    || (instr[6:0] == OPC_LUI)     || (instr[6:0] == OPC_AUIPC)
                    || in_b_or_j;
   assign in_unknown = !in_known;

   // R11: one-cycle valid pipeline
   a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(imm_o) && $stable(target_o) && $stable(uimm_o));

   // R9: target is captured pc plus immediate
   a_r9_target_sum: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> target_o == $past(pc) + imm_o);

   // R4 / R6: branch and jump immediates are even
   a_r4_r6_even: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_b_or_j) |=> imm_o[0] == 1'b0);

   // R8: sign comes from instruction bit 31
   a_r8_sign_src: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_known) |=> imm_o[XLEN-1] == $past(instr[31]));

   // R7: unsupported opcodes give zero
   a_r7_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_unknown) |=> imm_o == '0);

   // R10: unsigned immediate never exceeds five bits
   a_r10_uimm_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> uimm_o[XLEN-1:UIMM_W] == '0);

   // R12: reset values
   always_comb begin
      if (!rst_n) begin
         a_r12_reset_zero: assert (out_valid == 1'b0 || $isunknown(out_valid));
      end
   end

endmodule

bind imm_target_unit imm_target_chk #(.XLEN(XLEN)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .instr     (instr),
   .pc        (pc),
   .out_valid (out_valid),
   .imm_o     (imm_o),
   .target_o  (target_o),
   .uimm_o    (uimm_o)
);

// File: tb/imm_target_unit_tb.sv
module imm_target_unit_tb_top;

   localparam int XLEN  = 32;
   localparam int NVEC  = 17;
   localparam int WDOG  = 5000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [XLEN-1:0] pc = '0;
   logic            out_valid;
   logic [XLEN-1:0] imm_o;
   logic [XLEN-1:0] target_o;
   logic [XLEN-1:0] uimm_o;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   imm_target_unit #(.XLEN(XLEN), .CSR_UIMM_EN(1'b1)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .instr     (instr),
      .pc        (pc),
      .out_valid (out_valid),
      .imm_o     (imm_o),
      .target_o  (target_o),
      .uimm_o    (uimm_o)
   );

   // {instr, pc, expected imm, expected uimm, requirement tag}
   localparam logic [31:0] VEC [NVEC][5] = '{
      '{32'hFFF00093, 32'h00001000, 32'hFFFFFFFF, 32'h0,  32'd2},  // R2 addi -1
      '{32'h7FF00103, 32'h00000040, 32'h000007FF, 32'h0,  32'd2},  // R2 load +2047
      '{32'h80000067, 32'h00004000, 32'hFFFFF800, 32'h0,  32'd2},  // R2 jalr -2048
      '{32'hFE002E23, 32'h00000010, 32'hFFFFFFFC, 32'h0,  32'd3},  // R3 store -4
      '{32'h00000AA3, 32'h00000010, 32'h00000015, 32'h0,  32'd3},  // R3 store +21
      '{32'hFE000CE3, 32'h00000100, 32'hFFFFFFF8, 32'h0,  32'd4},  // R4 branch -8
      '{32'h000000E3, 32'h00000100, 32'h00000800, 32'h0,  32'd4},  // R4 bit7 -> imm11
      '{32'h123450B7, 32'h00000000, 32'h12345000, 32'h0,  32'd5},  // R5 lui
      '{32'hFFFFF017, 32'h00002000, 32'hFFFFF000, 32'h0,  32'd5},  // R5 auipc
      '{32'h0010006F, 32'h00000200, 32'h00000800, 32'h0,  32'd6},  // R6 bit20 -> imm11
      '{32'hFFFFF06F, 32'h00000200, 32'hFFFFFFFE, 32'h0,  32'd6},  // R6 jal -2
      '{32'h0000106F, 32'h00000200, 32'h00001000, 32'h0,  32'd6},  // R6 bit12
      '{32'h002081B3, 32'h00000300, 32'h00000000, 32'h0,  32'd7},  // R7 reg-reg
      '{32'hFFFFFFFF, 32'h00000300, 32'h00000000, 32'h0,  32'd7},  // R7 unknown
      '{32'h000FD073, 32'h00000400, 32'h00000000, 32'h1F, 32'd10}, // R10 uimm 31
      '{32'h30055073, 32'h00000400, 32'h00000000, 32'h0A, 32'd10}, // R10 uimm 10
      '{32'h800F8013, 32'h00000400, 32'hFFFFF800, 32'h0,  32'd10}  // R10 non-system
   };

   task automatic check(input string req, input logic [XLEN-1:0] act,
                        input logic [XLEN-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w, input logic [XLEN-1:0] p);
      @(negedge clk);
      instr    = w;
      pc       = p;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      check("R12 out_valid", XLEN'(out_valid), '0);
      check("R12 imm_o", imm_o, '0);
      check("R12 target_o", target_o, '0);
      check("R12 uimm_o", uimm_o, '0);
      rst_n = 1'b1;

      // R1..R10 vector walk
      for (int i = 0; i < NVEC; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VEC[i][4], i);
         send(VEC[i][0], VEC[i][1]);
         check({tag, " R11 valid"}, XLEN'(out_valid), 1);
         check({tag, " imm"}, imm_o, VEC[i][2]);
         check({tag, " R9 target"}, target_o, VEC[i][1] + VEC[i][2]);
         check({tag, " uimm"}, uimm_o, VEC[i][3]);
         check({tag, " R8 sign"}, XLEN'(imm_o[XLEN-1]),
               ((VEC[i][0][6:0] == 7'b0110011) || (VEC[i][0][6:0] == 7'b1111111)
                || (VEC[i][0][6:0] == 7'b1110011)) ? 0 : XLEN'(VEC[i][0][31]));
      end

      // R1: same upper bits, only opcode differs (S vs B shapes)
      send(32'h00000FA3, 32'h0);           // store: imm = 0x1F
      check("R1 store shape", imm_o, 32'h0000001F);
      send(32'h00000FE3, 32'h0);           // branch: imm = 0x81E
      check("R1 branch shape", imm_o, 32'h0000081E);

      // R11: hold when in_valid low
      send(32'h00500093, 32'h00000100);    // addi +5
      @(negedge clk);
      instr    = 32'hFFF00093;
      pc       = 32'h00009000;
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R11 valid low", XLEN'(out_valid), 0);
      check("R11 imm held", imm_o, 32'h00000005);
      check("R11 target held", target_o, 32'h00000105);

      // R11: back-to-back issue, one-cycle latency
      @(negedge clk);
      instr = 32'h0010006F; pc = 32'h10; in_valid = 1'b1;
      @(negedge clk);
      check("R11 b2b first", target_o, 32'h00000810);
      instr = 32'hFE000CE3; pc = 32'h20;
      @(negedge clk);
      check("R11 b2b second", target_o, 32'h00000018);
      in_valid = 1'b0;

      // R9: target wraps around
      send(32'h0010006F, 32'hFFFFF900);
      check("R9 wrap", target_o, 32'h00000100);

      done = 1'b1;
   end

   initial begin
      while (!done && cycles < WDOG) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule